// File: doc/BRIEF.md
# Serial Configuration Chain Shift Engine

This block lets a host load a long external serial configuration chain a slice at a time. For each operation the host writes the data register with up to 32 bits of payload, a bit count and a one-hot chain select, and sets a request bit. The engine then produces a divided serial clock and sends the payload out least significant bit first. At the same time it captures the bits that the selected chain pushes back. When the last bit has moved, the engine clears the request bit. The bits that came back then sit left-aligned in the same 32-bit field.

A full chain can be many hundreds of bits long, so software issues a run of shift operations and finishes with one update request. The update request raises a commit strobe to the selected chain for one divided-clock period. A control register sets the divided clock as a power-of-two fraction of the core clock and holds a lane-bypass mask that is passed through to the chain side. While either request is in flight, host writes are dropped; reads stay available for polling.

Top module: `cfgchain_shifter`

## Requirements
- R1: After reset both registers read zero (divider exponent, bypass mask, select, count, payload and both request bits), ch_sclk is low and ch_upd is all zero.
- R2: With D = control bits [3:0], each high phase and each low phase of ch_sclk during a shift lasts 2^(D+1) core cycles, so one full period is 2^(D+2) core cycles.
- R3: Data register bits [36:32] hold N-1, and one shift operation produces exactly N rising edges of ch_sclk, for N from 1 to 32.
- R4: ch_sdo carries payload bit 0 first, then bit 1 and so on upward. It changes only while ch_sclk is low, so each bit is stable across the rising edge that the chain samples.
- R5: At each rising edge of ch_sclk the selected chain's ch_sdi bit enters payload bit 31 and the payload moves down one place. After an N-bit operation the returned bits occupy payload bits [31:32-N], with the first returned bit at 32-N.
- R6: Data register bit 37 is the shift request. It is set by a host write, reads 1 while the shift runs, and is cleared by hardware after the final falling edge. ch_sclk is high only while it is set.
- R7: Data register bit 38 is the update request. It drives ch_upd high for exactly 2^(D+2) core cycles with no ch_sclk rising edge during that time, and afterwards reads 0.
- R8: Data register bits [42:39] (one per chain) appear on ch_sel. Serial input is taken only from the selected chain, clocked data reaches only that chain, and ch_upd is raised only on selected bits.
- R9: Any host write to either register while bit 37 or bit 38 is set is ignored.
- R10: A write with both bit 37 and bit 38 set performs only the shift: no strobe appears and bit 38 reads 0.
- R11: Control bits [11:8] form the lane-bypass mask and drive cfg_bypass. Control bits outside [3:0] and [11:8] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 1 | 0 selects the control register, 1 the data register |
| host_wdata | input | 64 | Write data |
| host_rdata | output | 64 | Read data of the addressed register |
| ch_sclk | output | 1 | Divided serial shift clock |
| ch_sdo | output | 1 | Serial data toward the chains |
| ch_sdi | input | 4 | Serial data returned by each chain |
| ch_upd | output | 4 | Per-chain commit strobe |
| ch_sel | output | 4 | One-hot chain select |
| cfg_bypass | output | 4 | Lane-bypass mask |

## Verification
Each shift result is compared against a chain model that the bench derives arithmetically. A bit lost or doubled in the sequencer shows up in the returned payload and in the chain contents as soon as that operation ends. A bad divider state shows in the measured high and low phase lengths and in the edge count on the first operation after the exponent changes. A stuck request bit shows as a poll that never finishes. A wrong select or a leaking strobe corrupts the chains that were not selected, and this is checked after every operation.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;
    localparam int HW     = 64;
    localparam int SR_W   = 32;
    localparam int CNT_W  = $clog2(SR_W);
    localparam int NCH    = 4;
    localparam int NLANE  = 4;
    localparam int DIV_W  = 4;
    localparam int HALF_W = (1 << DIV_W) + 1;
    localparam int DPAD_W = HW - SR_W - CNT_W - 2 - NCH;
    localparam int CPAD_W = HW - 8 - NLANE;

    typedef struct packed {
        logic [DPAD_W-1:0] pad;
        logic [NCH-1:0]    sel;
        logic              upd;
        logic              shift;
        logic [CNT_W-1:0]  cnt;
        logic [SR_W-1:0]   sr;
    } dreg_t;

    typedef struct packed {
        logic [CPAD_W-1:0]  pad_hi;
        logic [NLANE-1:0]   bypass;
        logic [7-DIV_W:0]   pad_lo;
        logic [DIV_W-1:0]   div_exp;
    } creg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_UPD} eng_state_t;

    function automatic logic [HALF_W-1:0] half_len(input logic [DIV_W-1:0] e);
        return HALF_W'(1) << (32'(e) + 1);
    endfunction
endpackage

// File: rtl/cfgchain_clkdiv.sv
module cfgchain_clkdiv
    import cfgchain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_exp,
    output logic             tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] half;

    assign half = half_len(div_exp);
    assign tick = run && (cnt_q == half - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end
endmodule

// File: rtl/cfgchain_sdi_mux.sv
module cfgchain_sdi_mux #(
    parameter int N = 4
) (
    input  logic [N-1:0] sdi,
    input  logic [N-1:0] sel,
    output logic         bit_o
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = sdi[i] & sel[i];
    end

    assign bit_o = |gated;
endmodule

// File: rtl/cfgchain_engine.sv
module cfgchain_engine
    import cfgchain_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  dreg_t wdata,
    input  logic  tick,
    input  logic  sdi_bit,
    output dreg_t dreg,
    output logic  run,
    output logic  sclk,
    output logic  sdo,
    output logic  upd_act
);
    eng_state_t       state_q;
    logic [SR_W-1:0]  sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bitn_q;
    logic [NCH-1:0]   sel_q;
    logic             shift_q;
    logic             upd_q;
    logic             phase_q;
    logic             sclk_q;
    logic             sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sr_q    <= '0;
            cnt_q   <= '0;
            bitn_q  <= '0;
            sel_q   <= '0;
            shift_q <= 1'b0;
            upd_q   <= 1'b0;
            phase_q <= 1'b0;
            sclk_q  <= 1'b0;
            sdo_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        sr_q    <= wdata.sr;
                        cnt_q   <= wdata.cnt;
                        sel_q   <= wdata.sel;
                        bitn_q  <= '0;
                        phase_q <= 1'b0;
                        if (wdata.shift) begin
                            shift_q <= 1'b1;
                            sdo_q   <= wdata.sr[0];
                            state_q <= ST_LOW;
                        end else if (wdata.upd) begin
                            upd_q   <= 1'b1;
                            state_q <= ST_UPD;
                        end
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        sclk_q  <= 1'b1;
                        sr_q    <= {sdi_bit, sr_q[SR_W-1:1]};
                        state_q <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        if (bitn_q == cnt_q) begin
                            shift_q <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            bitn_q  <= bitn_q + CNT_W'(1);
                            sdo_q   <= sr_q[0];
                            state_q <= ST_LOW;
                        end
                    end
                end
                ST_UPD: begin
                    if (tick) begin
                        if (phase_q) begin
                            upd_q   <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            phase_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dreg       = '0;
        dreg.sel   = sel_q;
        dreg.upd   = upd_q;
        dreg.shift = shift_q;
        dreg.cnt   = cnt_q;
        dreg.sr    = sr_q;
    end

    assign run     = (state_q != ST_IDLE);
    assign sclk    = sclk_q;
    assign sdo     = sdo_q;
    assign upd_act = (state_q == ST_UPD);
endmodule

// File: rtl/cfgchain_shifter.sv
module cfgchain_shifter
    import cfgchain_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_addr,
    input  logic [HW-1:0]    host_wdata,
    output logic [HW-1:0]    host_rdata,
    output logic             ch_sclk,
    output logic             ch_sdo,
    input  logic [NCH-1:0]   ch_sdi,
    output logic [NCH-1:0]   ch_upd,
    output logic [NCH-1:0]   ch_sel,
    output logic [NLANE-1:0] cfg_bypass
);
    creg_t ctrl_q;
    creg_t ctrl_w;
    dreg_t dreg;
    logic  busy_w;
    logic  run;
    logic  tick;
    logic  sdi_bit;
    logic  upd_act;
    logic  load_data;

    assign ctrl_w    = creg_t'(host_wdata);
    assign busy_w    = dreg.shift | dreg.upd;
    assign load_data = host_wr && host_addr && !busy_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (host_wr && !host_addr && !busy_w) begin
            ctrl_q.div_exp <= ctrl_w.div_exp;
            ctrl_q.bypass  <= ctrl_w.bypass;
        end
    end

    cfgchain_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_exp (ctrl_q.div_exp),
        .tick    (tick)
    );

    cfgchain_sdi_mux #(.N(NCH)) u_mux (
        .sdi   (ch_sdi),
        .sel   (dreg.sel),
        .bit_o (sdi_bit)
    );

    cfgchain_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .load    (load_data),
        .wdata   (dreg_t'(host_wdata)),
        .tick    (tick),
        .sdi_bit (sdi_bit),
        .dreg    (dreg),
        .run     (run),
        .sclk    (ch_sclk),
        .sdo     (ch_sdo),
        .upd_act (upd_act)
    );

    assign ch_sel     = dreg.sel;
    assign ch_upd     = dreg.sel & {NCH{upd_act}};
    assign cfg_bypass = ctrl_q.bypass;
    assign host_rdata = host_addr ? HW'(dreg) : HW'(ctrl_q);
endmodule

// File: rtl/cfgchain_chk.sv
module cfgchain_chk
    import cfgchain_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic             host_addr,
    input logic             ch_sclk,
    input logic             ch_sdo,
    input logic [NCH-1:0]   ch_upd,
    input logic [NCH-1:0]   ch_sel,
    input logic [NLANE-1:0] cfg_bypass,
    input logic             busy
);
    AST_SCLK_NOT_IN_UPD: assert property (@(posedge clk) disable iff (rst)
        (|ch_upd) |-> !ch_sclk); // R7

    AST_UPD_WITHIN_SEL: assert property (@(posedge clk) disable iff (rst)
        (ch_upd & ~ch_sel) == '0); // R8

    AST_SDO_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_sdo) |-> !ch_sclk); // R4

    AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        ch_sclk |-> busy); // R6

    AST_BYPASS_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && !host_addr) |=> $stable(cfg_bypass)); // R9
endmodule

bind cfgchain_shifter cfgchain_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .ch_sclk    (ch_sclk),
    .ch_sdo     (ch_sdo),
    .ch_upd     (ch_upd),
    .ch_sel     (ch_sel),
    .cfg_bypass (cfg_bypass),
    .busy       (busy_w)
);

// File: tb/cfgchain_shifter_tb_top.sv
`timescale 1ns/1ps
module cfgchain_shifter_tb_top;
    localparam int NC = 4;
    localparam int CL = 40;
    localparam int SHIFT_BIT = 37;
    localparam int UPD_BIT = 38;
    localparam int SEL_LSB = 39;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0;
    logic host_addr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic ch_sclk, ch_sdo;
    logic [NC-1:0] ch_sdi, ch_upd, ch_sel;
    logic [3:0] cfg_bypass;
    logic preload = 1'b0;

    always #2 clk = ~clk;

    cfgchain_shifter dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ch_sclk(ch_sclk), .ch_sdo(ch_sdo), .ch_sdi(ch_sdi),
        .ch_upd(ch_upd), .ch_sel(ch_sel), .cfg_bypass(cfg_bypass)
    );

    // External chain model: shifts toward bit 0, new bit enters at the top.
    logic [CL-1:0] chain_m [NC];
    logic [CL-1:0] shadow_m [NC];
    logic [CL-1:0] exp_chain [NC];
    logic [CL-1:0] exp_shadow [NC];
    wire upd_any = |ch_upd;

    function automatic logic [CL-1:0] init_val(input int i);
        return 40'h5A_C3F0_0F1E ^ (CL'(i) * 40'h11_1357_9BDF);
    endfunction

    for (genvar i = 0; i < NC; i++) begin : g_sdi
        assign ch_sdi[i] = chain_m[i][0];
    end

    always @(posedge ch_sclk or posedge preload) begin
        for (int i = 0; i < NC; i++) begin
            if (preload) chain_m[i] <= init_val(i);
            else if (ch_sel[i]) chain_m[i] <= {ch_sdo, chain_m[i][CL-1:1]};
        end
    end

    always @(posedge upd_any or posedge preload) begin
        for (int i = 0; i < NC; i++) begin
            if (preload) shadow_m[i] <= '0;
            else if (ch_upd[i]) shadow_m[i] <= chain_m[i];
        end
    end

    // Port monitor sampled away from the active edge
    int rises = 0, upd_cyc = 0, hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0, sdo_bad = 0;
    logic prev_sclk = 1'b0, prev_sdo = 1'b0;
    always @(negedge clk) begin
        if (ch_sclk) begin
            if (!prev_sclk) begin last_lo = lo_cnt; lo_cnt = 0; rises++; end
            hi_cnt++;
        end else begin
            if (prev_sclk) begin last_hi = hi_cnt; hi_cnt = 0; end
            lo_cnt++;
        end
        if (prev_sclk && ch_sclk && ch_sdo != prev_sdo) sdo_bad++;
        if (upd_any) upd_cyc++;
        prev_sclk = ch_sclk;
        prev_sdo = ch_sdo;
    end

    int checks = 0, fails = 0;
    bit timed_out = 0;
    int cur_div = 0;

    task automatic chk(input string req, input bit ok, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [63:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [63:0] v);
        @(negedge clk);
        host_addr = a;
        #0.5 v = host_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [63:0] v;
        ok = 0;
        for (int k = 0; k < 20000; k++) begin
            rd(1'b1, v);
            if (!v[SHIFT_BIT] && !v[UPD_BIT]) begin ok = 1; break; end
        end
    endtask

    task automatic set_ctrl(input int d, input logic [3:0] byp);
        wr(1'b0, {52'h0, byp, 4'h0, 4'(d)});
        cur_div = d;
    endtask

    task automatic check_chains(input string req);
        for (int j = 0; j < NC; j++)
            chk(req, chain_m[j] == exp_chain[j], 64'(chain_m[j]), 64'(exp_chain[j]));
    endtask

    task automatic do_shift(input int ch, input int n, input logic [31:0] d, input bit also_upd);
        logic [63:0] w, v;
        logic [CL-1:0] o;
        longint unsigned m;
        int r0, u0;
        bit ok;
        w = '0;
        w[31:0] = d;
        w[36:32] = 5'(n - 1);
        w[SHIFT_BIT] = 1'b1;
        w[UPD_BIT] = also_upd;
        w[SEL_LSB + ch] = 1'b1;
        r0 = rises; u0 = upd_cyc;
        wr(1'b1, w);
        rd(1'b1, v);
        chk("R6 busy after start", v[SHIFT_BIT] == 1'b1, 64'(v[SHIFT_BIT]), 1);
        wait_idle(ok);
        chk("R6 busy clears", ok, 64'(ok), 1);
        rd(1'b1, v);
        m = (64'd1 << n) - 1;
        o = exp_chain[ch];
        chk("R5 returned bits", 64'(v[31:0] >> (32 - n)) == (64'(o) & m),
            64'(v[31:0] >> (32 - n)), 64'(o) & m);
        chk("R3 rising edge count", (rises - r0) == n, 64'(rises - r0), 64'(n));
        exp_chain[ch] = (o >> n) | (CL'(64'(d) & m) << (CL - n));
        check_chains("R4 R8 chain contents");
        chk("R8 select output", ch_sel == NC'(1 << ch), 64'(ch_sel), 64'(1 << ch));
        if (n >= 2) begin
            chk("R2 high phase", last_hi == (1 << (cur_div + 1)), 64'(last_hi), 64'(1 << (cur_div + 1)));
            chk("R2 low phase", last_lo == (1 << (cur_div + 1)), 64'(last_lo), 64'(1 << (cur_div + 1)));
        end
        if (also_upd) begin
            chk("R10 no strobe", upd_cyc == u0, 64'(upd_cyc - u0), 0);
            chk("R10 update bit reads 0", v[UPD_BIT] == 1'b0, 64'(v[UPD_BIT]), 0);
            for (int j = 0; j < NC; j++)
                chk("R10 shadows unchanged", shadow_m[j] == exp_shadow[j], 64'(shadow_m[j]), 64'(exp_shadow[j]));
        end
    endtask

    task automatic do_update(input int ch);
        logic [63:0] w, v;
        int r0, u0;
        bit ok;
        w = '0;
        w[UPD_BIT] = 1'b1;
        w[SEL_LSB + ch] = 1'b1;
        r0 = rises; u0 = upd_cyc;
        wr(1'b1, w);
        wait_idle(ok);
        chk("R7 update completes", ok, 64'(ok), 1);
        rd(1'b1, v);
        chk("R7 update bit clears", v[UPD_BIT] == 1'b0, 64'(v[UPD_BIT]), 0);
        chk("R7 strobe length", (upd_cyc - u0) == (1 << (cur_div + 2)), 64'(upd_cyc - u0), 64'(1 << (cur_div + 2)));
        chk("R7 no clock during strobe", rises == r0, 64'(rises - r0), 0);
        exp_shadow[ch] = exp_chain[ch];
        for (int j = 0; j < NC; j++)
            chk("R8 update only selected", shadow_m[j] == exp_shadow[j], 64'(shadow_m[j]), 64'(exp_shadow[j]));
    endtask

    task automatic run_all();
        logic [63:0] v, w;
        bit ok;
        int r0;
        // R1 reset state
        rd(1'b0, v);
        chk("R1 control reset", v == 64'h0, v, 0);
        rd(1'b1, v);
        chk("R1 data reset", v == 64'h0, v, 0);
        chk("R1 sclk low", ch_sclk == 1'b0, 64'(ch_sclk), 0);
        chk("R1 no strobe", ch_upd == '0, 64'(ch_upd), 0);
        // R11 bypass field and zero padding
        wr(1'b0, 64'hFFFF_FFFF_FFFF_FA03);
        rd(1'b0, v);
        chk("R11 control readback", v == 64'h0A03, v, 64'h0A03);
        chk("R11 bypass output", cfg_bypass == 4'hA, 64'(cfg_bypass), 64'hA);
        // Sweep of divider, count and chain
        for (int d = 0; d < 3; d++) begin
            set_ctrl(d, 4'h5);
            for (int n = 1; n <= 32; n++) begin
                if (d == 0 || (n % 5) == 1 || n == 32)
                    do_shift(n % NC, n, (32'h9E37_79B9 * 32'(n)) ^ 32'(d * 32'h0101_0101), 1'b0);
            end
            do_update((d + 1) % NC);
        end
        // R9 writes during a shift are ignored
        set_ctrl(2, 4'h6);
        w = '0;
        w[31:0] = 32'hC001_D00D;
        w[36:32] = 5'd31;
        w[SHIFT_BIT] = 1'b1;
        w[SEL_LSB + 1] = 1'b1;
        r0 = rises;
        wr(1'b1, w);
        repeat (20) @(negedge clk);
        wr(1'b0, 64'h0000_0000_0000_0F00);
        w[SEL_LSB + 1] = 1'b0;
        w[SEL_LSB + 3] = 1'b1;
        w[31:0] = 32'h1234_5678;
        wr(1'b1, w);
        wait_idle(ok);
        chk("R9 shift completes", ok, 64'(ok), 1);
        chk("R9 bypass kept", cfg_bypass == 4'h6, 64'(cfg_bypass), 64'h6);
        chk("R9 edge count kept", (rises - r0) == 32, 64'(rises - r0), 32);
        rd(1'b1, v);
        chk("R9 result from first request", v[31:0] == exp_chain[1][31:0], 64'(v[31:0]), 64'(exp_chain[1][31:0]));
        exp_chain[1] = (exp_chain[1] >> 32) | (CL'(32'hC001_D00D) << (CL - 32));
        check_chains("R9 chains after ignored write");
        chk("R9 select kept", ch_sel == 4'b0010, 64'(ch_sel), 64'h2);
        // R10 both request bits
        set_ctrl(0, 4'h0);
        do_shift(0, 4, 32'h0000_000B, 1'b1);
        do_update(3);
        chk("R4 sdo stable while sclk high", sdo_bad == 0, 64'(sdo_bad), 0);
    endtask

    initial begin
        for (int i = 0; i < NC; i++) begin
            exp_chain[i] = init_val(i);
            exp_shadow[i] = '0;
        end
        #1 preload = 1'b1;
        #1 preload = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk("watchdog", 1'b0, 1, 0);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule